// File: doc/BRIEF.md
# IDE Function Configuration Space

This block holds the 256-byte configuration space of a two-channel IDE controller function. A configuration agent reaches it through one shared byte address and a size code. Reads return one, two or four consecutive bytes at once, assembled combinationally. Writes land on the next rising clock edge, and each byte goes through its own write policy first.

Most bytes are plain storage. The identification bytes are fixed and cannot be written, and the command byte keeps only its two enable bits. Two bytes of the command/status word are read-only. Two address windows reject every write that starts inside them. The I/O base register of the bus-master block always carries its I/O indicator bit. Whenever a write changes any byte of that base register, the block raises a one-cycle update pulse. At the same time it presents the new 16-port-aligned base, so the bus-master port decoder can reload.

Top module: `ide_cfg_space`

## Requirements
- R1: A read returns byte addr+i at bits 8i+7:8i for i below the access width. The access width is 1 byte for size code 0, 2 bytes for code 1, and 4 bytes for codes 2 and 3. Unused upper bits read 0. Byte addresses wrap modulo 256 for both reads and writes.
- R2: A write whose first byte address is in 0x10..0x1F or 0x24..0x3F changes no byte and raises no update pulse. A write that starts outside these ranges still writes every byte it covers, including bytes inside them.
- R3: A write to byte 0x04 stores only data bits 0 and 2; every other bit of that byte becomes 0.
- R4: Writes to bytes 0x05 and 0x06 leave them unchanged.
- R5: A write to byte 0x20 stores the data with bit 1 cleared and bit 0 set.
- R6: bar_upd is high for exactly the one cycle after a write clock edge at which any of bytes 0x20..0x23 changed value; otherwise it is low.
- R7: bar_base equals bytes 0x23..0x20 as a little-endian word with bits 3:0 forced to 0. It shows the new value in the same cycle as the bar_upd pulse.
- R8: After reset, byte 0x04 reads 0x01, bytes 0x06/0x07 read 0x80/0x02, byte 0x20 reads 0x01 and byte 0x44 reads 0x00.
- R9: After reset, bytes 0x40/0x41 read 0x00/0x80 when CH0_EN is 1 and both read 0 otherwise. Bytes 0x42/0x43 do the same under CH1_EN.
- R10: Bytes 0x00..0x01 always read VEND_ID and bytes 0x02..0x03 always read DEV_ID, both little-endian. Bytes 0x09/0x0A/0x0B always read 0x80/0x01/0x01 and byte 0x0E always reads 0x00. Writes to any of these bytes are ignored.
- R11: Every other byte stores the written data unchanged and resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | 8 | First byte address of the access |
| acc_size | input | 2 | Width code: 0 byte, 1 word, 2/3 dword |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | 32 | Write data, byte i at bits 8i+7:8i |
| rd_data | output | 32 | Combinational read data |
| bar_upd | output | 1 | One-cycle pulse after the base register changed |
| bar_base | output | 32 | Current bus-master I/O base, 16-byte aligned |

## Verification
The bench builds the block with CH0_EN at 1 and CH1_EN at 0, so a single reset shows both the enabled and the cleared timing-byte patterns. It also sets distinct non-zero VEND_ID and DEV_ID values. These make the identification reads and the writes that wrap from 0xFF into byte 0x00 visibly differ from zero storage. Writes that straddle a window edge, repeated writes of an unchanged base and single-byte base changes exercise the exact conditions under which the update pulse fires.

// File: rtl/ide_cfg_pkg.sv
// Package: shared byte type and per-address rules of the IDE configuration
// space. Assumes an 8-bit byte address space of 256 entries.
package ide_cfg_pkg;

    typedef logic [7:0] cfg_byte_t;

    localparam int          CFG_BYTES   = 256;
    localparam int          LANES       = 4;
    localparam logic [7:0]  A_CMD       = 8'h04;
    localparam logic [7:0]  A_BAR0      = 8'h20;
    localparam logic [7:0]  A_TIM0      = 8'h40;
    localparam cfg_byte_t   CMD_KEEP    = 8'h05;

    // Number of bytes covered by a size code.
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // True when a write starting here must be dropped entirely.
    function automatic logic start_blocked(input logic [7:0] a);
        return ((a >= 8'h10) && (a <= 8'h1F)) || ((a >= 8'h24) && (a <= 8'h3F));
    endfunction

    // True for bytes that no write may alter.
    function automatic logic byte_fixed(input logic [7:0] a);
        case (a)
            8'h00, 8'h01, 8'h02, 8'h03, 8'h05, 8'h06,
            8'h09, 8'h0A, 8'h0B, 8'h0E: return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

    // Value stored for a write of d to address a.
    function automatic cfg_byte_t write_policy(input logic [7:0] a, input cfg_byte_t d);
        if (a == A_CMD)       return d & CMD_KEEP;
        else if (a == A_BAR0) return (d & 8'hFC) | 8'h01;
        else                  return d;
    endfunction

    // Reset contents of every byte.
    function automatic cfg_byte_t reset_byte(input logic [7:0] a, input logic [15:0] vend,
                                             input logic [15:0] dev, input logic ch0,
                                             input logic ch1);
        case (a)
            8'h00:   return vend[7:0];
            8'h01:   return vend[15:8];
            8'h02:   return dev[7:0];
            8'h03:   return dev[15:8];
            8'h04:   return 8'h01;
            8'h06:   return 8'h80;
            8'h07:   return 8'h02;
            8'h09:   return 8'h80;
            8'h0A:   return 8'h01;
            8'h0B:   return 8'h01;
            8'h20:   return 8'h01;
            8'h41:   return ch0 ? 8'h80 : 8'h00;
            8'h43:   return ch1 ? 8'h80 : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/ide_cfg_lane.sv
// Module: one byte lane of an access. Computes the lane's byte address and
// decides whether it writes. Applies the byte's write policy and flags a
// change of a base-register byte. Assumes the caller supplies the current
// stored value at lane_addr.
module ide_cfg_lane
    import ide_cfg_pkg::*;
#(
    parameter int LANE = 0
) (
    input  logic [7:0] base_addr,
    input  logic [2:0] nbytes,
    input  logic       wr_en,
    input  logic       blocked,
    input  cfg_byte_t  wbyte,
    input  cfg_byte_t  old_byte,
    output logic [7:0] lane_addr,
    output logic       lane_on,
    output logic       lane_we,
    output cfg_byte_t  lane_val,
    output logic       lane_bar_chg
);

    // Lane address, activity and filtered write value.
    always_comb begin
        lane_addr    = base_addr + 8'(LANE);
        lane_on      = (3'(LANE) < nbytes);
        lane_we      = wr_en && lane_on && !blocked && !byte_fixed(lane_addr);
        lane_val     = write_policy(lane_addr, wbyte);
        lane_bar_chg = lane_we && (lane_addr[7:2] == A_BAR0[7:2]) && (lane_val != old_byte);
    end

endmodule

// File: rtl/ide_cfg_bar_evt.sv
// Module: turns a base-register change seen at a write edge into a
// one-cycle pulse and presents the 16-port-aligned base. Assumes bar_raw
// is the stored register, already holding the new value after the edge.
module ide_cfg_bar_evt #(
    parameter int AW    = 32,
    parameter int ALIGN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chg,
    input  logic [AW-1:0] bar_raw,
    output logic          bar_upd,
    output logic [AW-1:0] bar_base
);

    // Register the change flag into the update pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) bar_upd <= 1'b0;
        else        bar_upd <= chg;
    end

    // Mask the low address bits covered by the port window.
    always_comb bar_base = {bar_raw[AW-1:ALIGN], {ALIGN{1'b0}}};

    // A pulse means the stored base differs from one cycle earlier.
    p_upd_changed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bar_upd |-> (bar_raw != $past(bar_raw)));

    // The I/O indicator bit of the base register is always set.
    p_io_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bar_raw[0] == 1'b1);

endmodule

// File: rtl/ide_cfg_space.sv
// Module: 256-byte configuration space of a two-channel IDE function.
// Combinational multi-byte reads, edge-triggered policy-filtered writes,
// and a base-update event for the bus-master I/O window. Assumes a single
// agent presents one access at a time; addresses wrap modulo 256.
module ide_cfg_space
    import ide_cfg_pkg::*;
#(
    parameter logic [15:0] VEND_ID = 16'h1AB2,
    parameter logic [15:0] DEV_ID  = 16'h7C3E,
    parameter bit          CH0_EN  = 1'b1,
    parameter bit          CH1_EN  = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  acc_addr,
    input  logic [1:0]  acc_size,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        bar_upd,
    output logic [31:0] bar_base
);

    localparam int DW = 8 * LANES;

    cfg_byte_t  mem [CFG_BYTES];
    logic [2:0] nbytes;
    logic       blocked;
    logic [7:0] l_addr [LANES];
    logic       l_on   [LANES];
    logic       l_we   [LANES];
    cfg_byte_t  l_val  [LANES];
    logic [LANES-1:0] l_chg;
    logic [DW-1:0]    bar_raw;

    // Decode access width and the start-address write windows.
    always_comb begin
        nbytes  = size_bytes(acc_size);
        blocked = start_blocked(acc_addr);
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        ide_cfg_lane #(.LANE(k)) u_lane (
            .base_addr    (acc_addr),
            .nbytes       (nbytes),
            .wr_en        (wr_en),
            .blocked      (blocked),
            .wbyte        (wr_data[8*k +: 8]),
            .old_byte     (mem[l_addr[k]]),
            .lane_addr    (l_addr[k]),
            .lane_on      (l_on[k]),
            .lane_we      (l_we[k]),
            .lane_val     (l_val[k]),
            .lane_bar_chg (l_chg[k])
        );
        // Place this lane's byte into the read word.
        always_comb rd_data[8*k +: 8] = l_on[k] ? mem[l_addr[k]] : 8'h00;
        // Gather the stored base register byte by byte.
        always_comb bar_raw[8*k +: 8] = mem[A_BAR0 + 8'(k)];
    end

    // Byte storage: reset contents, then per-lane writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < CFG_BYTES; j++)
                mem[j] <= reset_byte(8'(j), VEND_ID, DEV_ID, CH0_EN, CH1_EN);
        end else begin
            for (int k = 0; k < LANES; k++)
                if (l_we[k]) mem[l_addr[k]] <= l_val[k];
        end
    end

    ide_cfg_bar_evt #(.AW(DW), .ALIGN(4)) u_bar (
        .clk      (clk),
        .rst_n    (rst_n),
        .chg      (|l_chg),
        .bar_raw  (bar_raw),
        .bar_upd  (bar_upd),
        .bar_base (bar_base)
    );

    // Only enable bits of the command byte can ever be set.
    p_cmd_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem[A_CMD] & ~CMD_KEEP) == 8'h00);

    // Status bytes 5 and 6 never move after reset.
    p_status_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mem[5]) && $stable(mem[6]));

    // A write starting in a dropped window causes no update pulse.
    p_window_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && blocked) |=> !bar_upd);

    // An update pulse only follows a write strobe.
    p_upd_after_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bar_upd |-> $past(wr_en));

    // Class code bytes keep their fixed values.
    p_class_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mem[9]) && $stable(mem[10]) && $stable(mem[11]));

endmodule

// File: tb/ide_cfg_space_bench.sv
module ide_cfg_space_bench;
    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  acc_addr = 8'h00;
    logic [1:0]  acc_size = 2'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = 32'h0;
    logic [31:0] rd_data;
    logic        bar_upd;
    logic [31:0] bar_base;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PER/2) clk = ~clk;

    ide_cfg_space #(.VEND_ID(16'h1AB2), .DEV_ID(16'h7C3E), .CH0_EN(1'b1), .CH1_EN(1'b0))
    u_ide_cfg_space (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_size(acc_size),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .bar_upd(bar_upd), .bar_base(bar_base)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [1:0]  sz;
        logic [31:0] d;
        logic [31:0] e;   // read: rd_data; write: expected bar_upd
        logic [3:0]  r;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 2'd2, 32'h0, 32'h7C3E1AB2, 4'd10}, // R10 ids
        '{1'b0, 8'h04, 2'd2, 32'h0, 32'h02800001, 4'd8},  // R8 cmd/status
        '{1'b0, 8'h08, 2'd2, 32'h0, 32'h01018000, 4'd10}, // R10 class
        '{1'b0, 8'h0E, 2'd0, 32'h0, 32'h00000000, 4'd10}, // R10 header
        '{1'b0, 8'h40, 2'd2, 32'h0, 32'h00008000, 4'd9},  // R9 timing
        '{1'b0, 8'h20, 2'd2, 32'h0, 32'h00000001, 4'd8},  // R8 base reset
        '{1'b0, 8'h44, 2'd0, 32'h0, 32'h00000000, 4'd8},  // R8 byte 0x44
        '{1'b1, 8'h04, 2'd2, 32'hFFFFFFFF, 32'h0, 4'd3},  // R3 masked write
        '{1'b0, 8'h04, 2'd2, 32'h0, 32'hFF800005, 4'd3},  // R3
        '{1'b1, 8'h05, 2'd1, 32'h0000AA55, 32'h0, 4'd4},  // R4
        '{1'b0, 8'h04, 2'd2, 32'h0, 32'hFF800005, 4'd4},  // R4
        '{1'b1, 8'h10, 2'd2, 32'hDEADBEEF, 32'h0, 4'd2},  // R2 window
        '{1'b0, 8'h10, 2'd2, 32'h0, 32'h00000000, 4'd2},  // R2
        '{1'b1, 8'h30, 2'd0, 32'h00000055, 32'h0, 4'd2},  // R2 window
        '{1'b0, 8'h30, 2'd0, 32'h0, 32'h00000000, 4'd2},  // R2
        '{1'b1, 8'h0E, 2'd2, 32'h44332211, 32'h0, 4'd2},  // R2 straddle
        '{1'b0, 8'h0E, 2'd2, 32'h0, 32'h44332200, 4'd2},  // R2
        '{1'b1, 8'h20, 2'd2, 32'h0000C0FF, 32'h1, 4'd6},  // R6 change
        '{1'b0, 8'h20, 2'd2, 32'h0, 32'h0000C0FD, 4'd5},  // R5
        '{1'b1, 8'h20, 2'd2, 32'h0000C0FF, 32'h0, 4'd6},  // R6 no change
        '{1'b1, 8'h22, 2'd0, 32'h00000001, 32'h1, 4'd6},  // R6 one byte
        '{1'b1, 8'h1E, 2'd2, 32'hFFFFFFFF, 32'h0, 4'd2},  // R2 start in window
        '{1'b0, 8'h20, 2'd2, 32'h0, 32'h0001C0FD, 4'd2},  // R2
        '{1'b1, 8'h09, 2'd0, 32'h00000000, 32'h0, 4'd10}, // R10
        '{1'b0, 8'h08, 2'd2, 32'h0, 32'h01018000, 4'd10}, // R10
        '{1'b0, 8'h41, 2'd1, 32'h0, 32'h00000080, 4'd1},  // R1 unaligned
        '{1'b1, 8'h44, 2'd0, 32'h0000007E, 32'h0, 4'd11}, // R11
        '{1'b0, 8'h44, 2'd0, 32'h0, 32'h0000007E, 4'd11}, // R11
        '{1'b1, 8'hFE, 2'd2, 32'h04030201, 32'h0, 4'd1},  // R1 wrap
        '{1'b0, 8'hFE, 2'd1, 32'h0, 32'h00000201, 4'd1},  // R1
        '{1'b0, 8'h00, 2'd1, 32'h0, 32'h00001AB2, 4'd1},  // R1 / R10
        '{1'b1, 8'h50, 2'd3, 32'hA1B2C3D4, 32'h0, 4'd11}, // R11
        '{1'b0, 8'h51, 2'd1, 32'h0, 32'h0000B2C3, 4'd1},  // R1
        '{1'b1, 8'h23, 2'd0, 32'h00000080, 32'h1, 4'd6}   // R6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Drive one access at a falling edge; sample just after the next rising edge.
    task automatic access(input logic wr, input logic [7:0] a, input logic [1:0] sz,
                          input logic [31:0] d);
        @(negedge clk);
        wr_en = wr; acc_addr = a; acc_size = sz; wr_data = d;
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R6 reset pulse", {31'h0, bar_upd}, 32'h0);
        check("R7 reset base", bar_base, 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].a, VECS[i].sz, VECS[i].d);
            if (VECS[i].wr)
                check($sformatf("R%0d vec %0d upd", VECS[i].r, i), {31'h0, bar_upd}, VECS[i].e);
            else
                check($sformatf("R%0d vec %0d read", VECS[i].r, i), rd_data, VECS[i].e);
        end

        // R7: base follows the stored bytes, aligned to 16 ports.
        check("R7 base after table", bar_base, 32'h8001C0F0);

        // R6/R7: one-cycle pulse with new base shown in the same cycle.
        access(1'b1, 8'h21, 2'd0, 32'h00000011);
        check("R6 pulse high", {31'h0, bar_upd}, 32'h1);
        check("R7 base with pulse", bar_base, 32'h800111F0);
        access(1'b0, 8'h21, 2'd0, 32'h0);
        check("R6 pulse ends", {31'h0, bar_upd}, 32'h0);

        // R5: writes with bit 1 set and bit 0 clear still read back as ...01.
        access(1'b1, 8'h20, 2'd0, 32'h000000A2);
        access(1'b0, 8'h20, 2'd0, 32'h0);
        check("R5 io bit forced", rd_data, 32'h000000A1);

        // Reset in the middle of the run.
        @(negedge clk) rst_n = 1'b0; wr_en = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R6 pulse after reset", {31'h0, bar_upd}, 32'h0);
        check("R7 base after reset", bar_base, 32'h0);
        access(1'b0, 8'h04, 2'd2, 32'h0);
        check("R8 cmd after reset", rd_data, 32'h02800001);
        access(1'b0, 8'h50, 2'd2, 32'h0);
        check("R11 storage cleared", rd_data, 32'h0);
        access(1'b0, 8'h40, 2'd2, 32'h0);
        check("R9 timing after reset", rd_data, 32'h00008000);
        access(1'b0, 8'h44, 2'd2, 32'h0);
        check("R8 byte 0x44 cleared", rd_data, 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule